// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block supervises software by counting down from a programmed value. If the count runs out before software restarts it, the block asks for a processor reset. A restart is accepted only after a two-word unlock on a dedicated register, so one errant store cannot keep the timer fed. Once the timer is armed, software cannot turn it off. The first interval after arming is a separate, longer timeout, which leaves room for system start-up.

Each time the timer expires, it raises a fixed-length reset request. It then puts its own control state back to defaults: it is disarmed, the reload value returns to its default, and any partial unlock is dropped. A tally of these expiries survives the request and is cleared only by the power-on reset `rst_ni`. When the tally reaches a give-up limit, the block latches a fault and holds the reset request high for good.

The write port decodes a 2-bit address: 0 is the reload value, 1 is control, 2 is the key, and 3 is unused.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on reset the outputs are as follows: `enabled_o` is 0, `count_o` is 0, `rst_req_o` is 0, `fault_o` is 0 and `bite_cnt_o` is 0.
- R2: A write to address 1 with data bit 0 set arms the timer and loads `count_o` with INIT_TIMEOUT (default 40) on that edge. While the timer is not armed, `count_o` stays 0 and no reset request is raised.
- R3: While the timer is armed and no restart is accepted, `count_o` falls by one on every clock until it reaches 0.
- R4: A write of 16'h5555 to address 2, followed by a write of 16'hAAAA to address 2 as the next write, restarts the timer. Idle cycles between the two writes are allowed. On the edge of the second write, `count_o` is loaded with the reload value.
- R5: The unlock is lost, and a following 16'hAAAA does nothing, in either of these cases: the 16'hAAAA write has no 16'h5555 just before it, or any other write comes between the two (any address, or any other key value). A repeated 16'h5555 keeps the unlock.
- R6: Address 0 holds the reload value that every accepted restart loads. Its default is RELOAD_DEF (20).
- R7: While the timer is armed, a write to address 1 with bit 0 clear leaves it armed.
- R8: Expiry happens on an edge where the timer is armed, `count_o` is 0 and no restart is accepted. On that edge `rst_req_o` rises and then stays high for exactly RST_LEN (16) cycles. On the same edge the timer is disarmed, `count_o` becomes 0, the reload value returns to RELOAD_DEF, and any unlock is dropped.
- R9: `bite_cnt_o` goes up by one at each expiry. It keeps its value through the reset request and is cleared only by `rst_ni`.
- R10: All writes are ignored while `rst_req_o` is high.
- R11: At the expiry that brings `bite_cnt_o` to BITE_LIMIT (3), `fault_o` rises. From then until `rst_ni`, `fault_o` and `rst_req_o` both stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 reload, 1 control, 2 key |
| wr_data_i | input | 16 | Write data |
| rst_req_o | output | 1 | Reset request to the processor |
| fault_o | output | 1 | Give-up fault, held until power-on reset |
| enabled_o | output | 1 | Timer is armed |
| count_o | output | CNT_W | Current down-count value |
| bite_cnt_o | output | BITE_W | Number of expiries since power-on reset |

## Verification
The hardest state to reach is the give-up fault. It needs three full expiries, each followed by a complete reset request during which all writes are dropped, and then a re-arm. The stimulus drives these expiries back to back. On the second one it confirms that the reload value has returned to its default, and on the last one it runs the timer out from the longer first timeout. The unlock corner cases are packed into one continuous run of writes on an armed timer: abort by another register, abort by a wrong key, a lone second key, and a repeated first key.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
  typedef enum logic [1:0] {
    ADDR_RELOAD = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_KEY    = 2'd2,
    ADDR_SPARE  = 2'd3
  } wdog_addr_e;

  localparam logic [15:0] KEY_ARM  = 16'h5555;
  localparam logic [15:0] KEY_FIRE = 16'hAAAA;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_keyed_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  output logic        restart_o
);
  logic armed_q;
  logic wr_key;

  always_comb begin
    wr_key    = wr_en_i && (wr_addr_i == ADDR_KEY);
    restart_o = armed_q && wr_key && (wr_data_i == KEY_FIRE);
  end

  // any write other than the arm word drops the unlock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (clr_i)   armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= wr_key && (wr_data_i == KEY_ARM);
  end

  // R5
  lone_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !$past(clr_i));
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int CNT_W        = 16,
  parameter int INIT_TIMEOUT = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_set_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             enabled_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  assign enabled_o = en_q;
  assign count_o   = cnt_q;
  assign expire_o  = en_q && (cnt_q == '0) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!en_q) begin
      if (en_set_i) begin
        en_q  <= 1'b1;
        cnt_q <= CNT_W'(INIT_TIMEOUT);
      end
    end else if (restart_i) begin
      cnt_q <= reload_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  sticky_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !clr_i |=> en_q);

  // R3
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !restart_i && !clr_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> cnt_q == '0);
endmodule

// File: rtl/wdog_bite_ctl.sv
module wdog_bite_ctl #(
  parameter int RST_LEN    = 16,
  parameter int BITE_LIMIT = 3,
  parameter int BITE_W     = $clog2(BITE_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  output logic              bite_o,
  output logic              rst_req_o,
  output logic              fault_o,
  output logic [BITE_W-1:0] bite_cnt_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [PW-1:0]     pulse_q;
  logic [BITE_W-1:0] bites_q;
  logic              fault_q;

  assign bite_o     = expire_i && !fault_q && (pulse_q == '0);
  assign rst_req_o  = (pulse_q != '0) || fault_q;
  assign fault_o    = fault_q;
  assign bite_cnt_o = bites_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      bites_q <= '0;
      fault_q <= 1'b0;
    end else if (bite_o) begin
      pulse_q <= PW'(RST_LEN);
      bites_q <= bites_q + 1'b1;
      if (bites_q == BITE_W'(BITE_LIMIT - 1)) fault_q <= 1'b1;
    end else if (pulse_q != '0) begin
      pulse_q <= pulse_q - 1'b1;
    end
  end

  // R8
  bite_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o |=> rst_req_o);

  // R11
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> fault_q && rst_req_o);

  // R9
  bite_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> bites_q >= $past(bites_q));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_keyed_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int INIT_TIMEOUT = 40,
  parameter int RELOAD_DEF   = 20,
  parameter int RST_LEN      = 16,
  parameter int BITE_LIMIT   = 3,
  parameter int BITE_W       = $clog2(BITE_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [15:0]       wr_data_i,
  output logic              rst_req_o,
  output logic              fault_o,
  output logic              enabled_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [BITE_W-1:0] bite_cnt_o
);
  logic             wr_ok;
  logic             en_set;
  logic             restart;
  logic             expire;
  logic             bite;
  logic [CNT_W-1:0] reload_q;

  // writes are dropped while the processor is held in reset
  assign wr_ok  = wr_en_i && !rst_req_o;
  assign en_set = wr_ok && (wr_addr_i == ADDR_CTRL) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               reload_q <= CNT_W'(RELOAD_DEF);
    else if (bite)                             reload_q <= CNT_W'(RELOAD_DEF);
    else if (wr_ok && wr_addr_i == ADDR_RELOAD) reload_q <= wr_data_i[CNT_W-1:0];
  end

  wdog_key_seq u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bite),
    .wr_en_i   (wr_ok),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .restart_o (restart)
  );

  wdog_down_cnt #(
    .CNT_W        (CNT_W),
    .INIT_TIMEOUT (INIT_TIMEOUT)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bite),
    .en_set_i  (en_set),
    .restart_i (restart),
    .reload_i  (reload_q),
    .enabled_o (enabled_o),
    .count_o   (count_o),
    .expire_o  (expire)
  );

  wdog_bite_ctl #(
    .RST_LEN    (RST_LEN),
    .BITE_LIMIT (BITE_LIMIT),
    .BITE_W     (BITE_W)
  ) u_bite (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .bite_o     (bite),
    .rst_req_o  (rst_req_o),
    .fault_o    (fault_o),
    .bite_cnt_o (bite_cnt_o)
  );

  // R4
  restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart && enabled_o |=> count_o == $past(reload_q));

  // R10
  ignore_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o && !enabled_o |=> !enabled_o);
endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rst_req, fault, enabled;
  logic [15:0] count;
  logic [1:0]  bites;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  wdog_keyed u_wdog_keyed (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rst_req_o  (rst_req),
    .fault_o    (fault),
    .enabled_o  (enabled),
    .count_o    (count),
    .bite_cnt_o (bites)
  );

  // {addr, data, restart expected, requirement}
  localparam logic [22:0] VECS [0:16] = '{
    {2'd2, 16'h5555, 1'b0, 4'd4},
    {2'd2, 16'hAAAA, 1'b1, 4'd4},
    {2'd2, 16'hAAAA, 1'b0, 4'd5},
    {2'd2, 16'h5555, 1'b0, 4'd5},
    {2'd0, 16'd100,  1'b0, 4'd5},
    {2'd2, 16'hAAAA, 1'b0, 4'd5},
    {2'd2, 16'h5555, 1'b0, 4'd5},
    {2'd2, 16'h5555, 1'b0, 4'd5},
    {2'd2, 16'hAAAA, 1'b1, 4'd5},
    {2'd2, 16'h1234, 1'b0, 4'd5},
    {2'd2, 16'h5555, 1'b0, 4'd5},
    {2'd2, 16'h1234, 1'b0, 4'd5},
    {2'd2, 16'hAAAA, 1'b0, 4'd5},
    {2'd1, 16'h0000, 1'b0, 4'd7},
    {2'd2, 16'h5555, 1'b0, 4'd5},
    {2'd1, 16'h0001, 1'b0, 4'd5},
    {2'd2, 16'hAAAA, 1'b0, 4'd5}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge; one rising edge per write
  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int prev;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 enabled", enabled, 0);
    chk("R1 count", count, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 fault", fault, 0);
    chk("R1 bites", bites, 0);

    // disarmed: key and clear-enable writes have no effect
    wr(2'd2, 16'h5555); wr(2'd2, 16'hAAAA); wr(2'd1, 16'h0000);
    chk("R2 count idle", count, 0);
    idle(60);
    chk("R2 no bite idle", rst_req, 0);
    chk("R2 still off", enabled, 0);

    wr(2'd0, 16'd100);
    wr(2'd1, 16'h0001);
    chk("R2 armed", enabled, 1);
    chk("R2 first timeout", count, 40);

    prev = 40;
    for (int i = 0; i < 17; i++) begin
      logic [22:0] v;
      int exp;
      v = VECS[i];
      wr(v[22:21], v[20:5]);
      exp = v[4] ? 100 : prev - 1;
      chk($sformatf("R%0d vec %0d", v[3:0], i), count, exp);
      prev = exp;
    end
    chk("R7 stays armed", enabled, 1);

    idle(5);
    chk("R3 decrement", count, prev - 5);

    wr(2'd2, 16'h5555); wr(2'd2, 16'hAAAA);
    chk("R6 reload used", count, 100);
    idle(100);
    chk("R8 zero no bite yet", rst_req, 0);
    chk("R3 reached zero", count, 0);
    idle(1);
    chk("R8 bite", rst_req, 1);
    chk("R8 disarmed", enabled, 0);
    chk("R9 bites one", bites, 1);
    wr(2'd1, 16'h0001);
    chk("R10 write ignored", enabled, 0);
    idle(14);
    chk("R8 pulse last", rst_req, 1);
    idle(1);
    chk("R8 pulse end", rst_req, 0);
    chk("R10 still off", enabled, 0);
    chk("R9 survives", bites, 1);

    wr(2'd1, 16'h0001);
    chk("R2 first timeout again", count, 40);
    wr(2'd2, 16'h5555); wr(2'd2, 16'hAAAA);
    chk("R6 default reload", count, 20);
    idle(21);
    chk("R9 bites two", bites, 2);
    chk("R11 no fault yet", fault, 0);
    idle(16);
    chk("R8 second end", rst_req, 0);

    wr(2'd1, 16'h0001);
    idle(40);
    chk("R3 ran out", count, 0);
    idle(1);
    chk("R11 fault", fault, 1);
    chk("R9 bites three", bites, 3);
    idle(40);
    chk("R11 rst held", rst_req, 1);
    chk("R11 fault held", fault, 1);
    wr(2'd1, 16'h0001);
    chk("R11 writes ignored", enabled, 0);

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R9 bites cleared", bites, 0);
    chk("R1 fault cleared", fault, 0);
    chk("R1 rst_req cleared", rst_req, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule